// File: doc/BRIEF.md
# Concatenating Funnel Shifter with Condition Flags

This block is the shift unit of a 32-bit integer datapath. It shifts a single register left logically, right logically or right arithmetically, and it also shifts a 64-bit value built from two registers, keeping the upper word of a left shift or the lower word of a right shift. The shift count comes from the low five bits of a count register or from a 5-bit immediate, whichever the issuing logic selects.

Each accepted operation produces its result one clock later on a registered output. Single-register shifts also set the carry, sign and zero flags, and they clear the overflow flag. Double-register shifts leave all four flags as they were, so a flag-setting shift placed before a funnel shift keeps its flags. Register selection and instruction decode belong to the surrounding pipeline. The unit sees only an operation code, two source words and the count inputs.

Top module: `fsh_unit`

## Requirements
- R1: An operation with `in_valid` high and a defined `op_sel` code raises `out_valid` for exactly one cycle after the next rising edge, with `result` and the flags updated on that same edge. With `in_valid` low, `out_valid` goes low and `result` holds its last value.
- R2: If `amt_from_imm` is 1, the shift count is `amt_imm` zero-extended. If it is 0, the count is `amt_reg[4:0]`, and bits 31..5 of `amt_reg` have no effect.
- R3: Code 0 (left logical) shifts `src_hi` left and fills vacated low bits with 0. Code 1 (right logical) shifts `src_hi` right and fills vacated high bits with 0.
- R4: Code 2 (right arithmetic) shifts `src_hi` right and fills vacated high bits with copies of `src_hi[31]`.
- R5: Code 3 (funnel left) shifts the 64-bit value {`src_hi`,`src_lo`} left and returns bits 63..32. A count of 0 returns `src_hi`.
- R6: Code 4 (funnel right) shifts {`src_hi`,`src_lo`} right logically and returns bits 31..0. A count of 0 returns `src_lo`.
- R7: Codes 3 and 4 leave `flag_cy`, `flag_ov`, `flag_s` and `flag_z` unchanged.
- R8: For codes 0 to 2, `flag_cy` is the last bit shifted out. That is `src_hi[32-n]` for a left shift and `src_hi[n-1]` for a right shift. A count of 0 clears `flag_cy` and returns `src_hi` unchanged.
- R9: For codes 0 to 2, `flag_ov` becomes 0, `flag_s` equals `result[31]`, and `flag_z` is 1 exactly when `result` is zero.
- R10: Codes 5, 6 and 7 are reserved. Such an operation produces no `out_valid` and changes neither `result` nor any flag.
- R11: While `rst` is high at a rising edge, `out_valid`, `result` and all four flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code: 0 left, 1 right logical, 2 right arithmetic, 3 funnel left, 4 funnel right |
| amt_from_imm | input | 1 | 1 selects the immediate count, 0 selects the count register |
| src_hi | input | 32 | Operand of single shifts; upper word of funnel shifts |
| src_lo | input | 32 | Lower word of funnel shifts |
| amt_reg | input | 32 | Count register; only bits 4..0 are used |
| amt_imm | input | 5 | Immediate shift count |
| out_valid | output | 1 | Result issued this cycle |
| result | output | 32 | Registered shift result |
| flag_cy | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
The unit holds little state: the result register, the valid bit and the four flags. An error in any of them shows at the ports in the cycle right after the operation that wrote it. A flag register written when it should have held its value, for example on a funnel shift or a reserved code, stays wrong until the next single-register shift. The bench compares every output on every cycle against a reference model, so such a stale flag is reported in each cycle it persists. The directed cases cover counts of 0 and 31, count registers with their upper bits set, and negative operands for the arithmetic fill.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_FSL = 3'd3,
    OP_FSR = 3'd4
  } shop_e;

  typedef struct packed {
    logic cy;
    logic ov;
    logic s;
    logic z;
  } flags_t;

  typedef struct packed {
    logic legal;
    logic left;
    logic arith;
    logic funnel;
  } shctl_t;

endpackage

// File: rtl/fsh_decode.sv
module fsh_decode
  import fsh_pkg::*;
(
  input  logic [2:0] op_sel,
  output shctl_t     ctl
);

  always_comb begin
    ctl = '0;
    case (op_sel)
      OP_SHL: begin ctl.legal = 1'b1; ctl.left = 1'b1; end
      OP_SHR: begin ctl.legal = 1'b1; end
      OP_SAR: begin ctl.legal = 1'b1; ctl.arith = 1'b1; end
      OP_FSL: begin ctl.legal = 1'b1; ctl.left = 1'b1; ctl.funnel = 1'b1; end
      OP_FSR: begin ctl.legal = 1'b1; ctl.funnel = 1'b1; end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/fsh_amount.sv
module fsh_amount #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic           from_imm,
  input  logic [W-1:0]   reg_amt,
  input  logic [SHW-1:0] imm_amt,
  output logic [SHW-1:0] amt
);

  logic [W-1:0] unused_hi;

  assign unused_hi = reg_amt;
  assign amt = from_imm ? imm_amt : unused_hi[SHW-1:0];

endmodule

// File: rtl/fsh_core.sv
module fsh_core #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  input  logic           funnel,
  output logic [W-1:0]   res,
  output logic           carry
);

  localparam int DW = 2 * W;

  logic [W-1:0]  fill;
  logic [DW-1:0] lword;
  logic [DW-1:0] rword;
  logic [DW:0]   lshift;
  logic [DW:0]   rshift;

  assign fill  = {W{arith & hi[W-1]}};
  assign lword = funnel ? {hi, lo} : {hi, {W{1'b0}}};
  assign rword = funnel ? {hi, lo} : {fill, hi};

  // one guard bit beyond the kept window catches the last bit shifted out
  assign lshift = {1'b0, lword} << amt;
  assign rshift = {rword, 1'b0} >> amt;

  always_comb begin
    if (left) begin
      res   = lshift[DW-1:W];
      carry = lshift[DW];
    end else begin
      res   = rshift[W:1];
      carry = rshift[0];
    end
  end

endmodule

// File: rtl/fsh_flags.sv
module fsh_flags
  import fsh_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         hold_req,
  input  logic [W-1:0] res,
  input  logic         carry,
  output flags_t       flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (upd) begin
      flags_q.cy <= carry;
      flags_q.ov <= 1'b0;
      flags_q.s  <= res[W-1];
      flags_q.z  <= (res == '0);
    end
  end

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> $stable(flags_q))
    else $error("funnel or reserved operation changed the flags");

endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
  import fsh_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     op_sel,
  input  logic           amt_from_imm,
  input  logic [W-1:0]   src_hi,
  input  logic [W-1:0]   src_lo,
  input  logic [W-1:0]   amt_reg,
  input  logic [SHW-1:0] amt_imm,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           flag_cy,
  output logic           flag_ov,
  output logic           flag_s,
  output logic           flag_z
);

  shctl_t         ctl;
  logic [SHW-1:0] amt;
  logic [W-1:0]   core_res;
  logic           core_carry;
  logic           accept;
  logic           upd_flags;
  logic           hold_flags;
  logic [W-1:0]   res_q;
  logic           vld_q;
  logic           last_single_q;
  flags_t         flags_q;

  fsh_decode u_dec (
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  fsh_amount #(.W(W), .SHW(SHW)) u_amt (
    .from_imm (amt_from_imm),
    .reg_amt  (amt_reg),
    .imm_amt  (amt_imm),
    .amt      (amt)
  );

  fsh_core #(.W(W), .SHW(SHW)) u_core (
    .hi     (src_hi),
    .lo     (src_lo),
    .amt    (amt),
    .left   (ctl.left),
    .arith  (ctl.arith),
    .funnel (ctl.funnel),
    .res    (core_res),
    .carry  (core_carry)
  );

  assign accept     = in_valid & ctl.legal;
  assign upd_flags  = accept & ~ctl.funnel;
  assign hold_flags = in_valid & (ctl.funnel | ~ctl.legal);

  fsh_flags #(.W(W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd_flags),
    .hold_req (hold_flags),
    .res      (core_res),
    .carry    (core_carry),
    .flags_q  (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q         <= '0;
      vld_q         <= 1'b0;
      last_single_q <= 1'b0;
    end else begin
      vld_q         <= accept;
      last_single_q <= upd_flags;
      if (accept) res_q <= core_res;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flag_cy   = flags_q.cy;
  assign flag_ov   = flags_q.ov;
  assign flag_s    = flags_q.s;
  assign flag_z    = flags_q.z;

  p_valid_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid)
    else $error("accepted operation produced no valid");

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ctl.legal) |=> (!out_valid && $stable(result)))
    else $error("reserved code produced output");

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    last_single_q |-> !flag_ov)
    else $error("overflow set after single shift");

  p_sign_r9: assert property (@(posedge clk) disable iff (rst)
    last_single_q |-> (flag_s == result[W-1]))
    else $error("sign flag disagrees with result");

  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    last_single_q |-> (flag_z == (result == '0)))
    else $error("zero flag disagrees with result");

endmodule

// File: tb/fsh_unit_bench.sv
module fsh_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic        amt_from_imm = 1'b0;
  logic [31:0] src_hi = '0;
  logic [31:0] src_lo = '0;
  logic [31:0] amt_reg = '0;
  logic [4:0]  amt_imm = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_cy, flag_ov, flag_s, flag_z;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] e_res = '0;
  logic        e_vld = 1'b0;
  logic        e_cy = 1'b0, e_ov = 1'b0, e_s = 1'b0, e_z = 1'b0;
  string       res_tag = "R11";
  string       flg_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  fsh_unit u_fsh_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .amt_from_imm(amt_from_imm), .src_hi(src_hi), .src_lo(src_lo),
    .amt_reg(amt_reg), .amt_imm(amt_imm), .out_valid(out_valid),
    .result(result), .flag_cy(flag_cy), .flag_ov(flag_ov),
    .flag_s(flag_s), .flag_z(flag_z)
  );

  always @(posedge clk) begin
    if (rst) begin
      e_res = '0; e_vld = 1'b0;
      e_cy = 1'b0; e_ov = 1'b0; e_s = 1'b0; e_z = 1'b0;
      res_tag = "R11"; flg_tag = "R11";
    end else begin
      e_vld = 1'b0;
      res_tag = "R1"; flg_tag = "R1";
      if (in_valid) begin
        int n;
        logic [63:0] cat;
        logic signed [31:0] sa;
        logic [31:0] r;
        logic c;
        n = amt_from_imm ? int'(amt_imm) : int'(amt_reg[4:0]);
        cat = {src_hi, src_lo};
        sa = src_hi;
        r = '0; c = 1'b0;
        case (op_sel)
          3'd0: begin r = src_hi << n; c = (n > 0) ? src_hi[32-n] : 1'b0; res_tag = "R3"; end
          3'd1: begin r = src_hi >> n; c = (n > 0) ? src_hi[n-1] : 1'b0; res_tag = "R3"; end
          3'd2: begin r = sa >>> n;    c = (n > 0) ? src_hi[n-1] : 1'b0; res_tag = "R4"; end
          3'd3: begin cat = cat << n; r = cat[63:32]; res_tag = "R5"; end
          3'd4: begin cat = cat >> n; r = cat[31:0];  res_tag = "R6"; end
          default: begin res_tag = "R10"; end
        endcase
        if (!amt_from_imm && amt_reg[31:5] != 0 && op_sel < 3'd5)
          res_tag = {res_tag, " R2"};
        if (op_sel < 3'd5) begin
          e_vld = 1'b1;
          e_res = r;
        end
        if (op_sel < 3'd3) begin
          e_cy = c; e_ov = 1'b0; e_s = r[31]; e_z = (r == 0);
          flg_tag = (n == 0) ? "R8 R9" : "R8";
        end else if (op_sel < 3'd5) begin
          flg_tag = "R7";
        end else begin
          flg_tag = "R10";
        end
      end
    end
  end

  task automatic chk1(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk1("R1", "out_valid", out_valid, e_vld);
      checks++;
      if (result !== e_res) begin
        errors++;
        $display("FAIL %s result: actual=%h expected=%h at %0t", res_tag, result, e_res, $time);
      end
      chk1(flg_tag, "flag_cy", flag_cy, e_cy);
      chk1(flg_tag == "R8" ? "R9" : flg_tag, "flag_ov", flag_ov, e_ov);
      chk1(flg_tag == "R8" ? "R9" : flg_tag, "flag_s", flag_s, e_s);
      chk1(flg_tag == "R8" ? "R9" : flg_tag, "flag_z", flag_z, e_z);
    end
  end

  task automatic issue(input logic [2:0] op, input logic imm_sel,
                       input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] areg, input logic [4:0] aimm);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; amt_from_imm = imm_sel;
    src_hi = hi; src_lo = lo; amt_reg = areg; amt_imm = aimm;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 left and right logical, counts 1, 0, 31
    issue(3'd0, 1'b1, 32'h8000_0001, 32'h0, 32'h0, 5'd1);
    issue(3'd0, 1'b1, 32'h1234_5678, 32'h0, 32'h0, 5'd0);
    issue(3'd0, 1'b1, 32'h0000_0003, 32'h0, 32'h0, 5'd31);
    issue(3'd1, 1'b1, 32'h8000_0001, 32'h0, 32'h0, 5'd1);
    issue(3'd1, 1'b1, 32'hF000_0000, 32'h0, 32'h0, 5'd31);
    // R4 arithmetic fill with negative and positive operands
    issue(3'd2, 1'b1, 32'h8000_0010, 32'h0, 32'h0, 5'd4);
    issue(3'd2, 1'b1, 32'h7FFF_FFFF, 32'h0, 32'h0, 5'd31);
    issue(3'd2, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd0);
    // R2 register count with upper bits set
    issue(3'd0, 1'b0, 32'h0000_00FF, 32'h0, 32'hFFFF_FFE3, 5'd17);
    issue(3'd2, 1'b0, 32'h8000_0000, 32'h0, 32'h1234_5660, 5'd9);
    // zero result sets zero flag, then funnels must keep flags (R7)
    issue(3'd1, 1'b1, 32'h0000_0001, 32'h0, 32'h0, 5'd1);
    issue(3'd3, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0, 5'd0);
    issue(3'd3, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0, 5'd8);
    issue(3'd3, 1'b0, 32'h0000_0001, 32'h8000_0000, 32'h0000_003F, 5'd0);
    issue(3'd4, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0, 5'd0);
    issue(3'd4, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0, 5'd12);
    issue(3'd4, 1'b1, 32'h8000_0001, 32'h0000_0000, 32'h0, 5'd31);
    // R10 reserved codes
    issue(3'd2, 1'b1, 32'h8000_0000, 32'h0, 32'h0, 5'd3);
    issue(3'd5, 1'b1, 32'h0000_0000, 32'h0, 32'h0, 5'd1);
    issue(3'd6, 1'b1, 32'h1111_1111, 32'h0, 32'h0, 5'd2);
    issue(3'd7, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h1, 5'd0);
    idle(); idle();
    // R11 reset in mid run
    issue(3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd4);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      in_valid     = ($urandom_range(0, 7) != 0);
      op_sel       = 3'($urandom_range(0, 7));
      amt_from_imm = 1'($urandom_range(0, 1));
      src_hi       = $urandom();
      src_lo       = $urandom();
      amt_reg      = $urandom();
      amt_imm      = 5'($urandom_range(0, 31));
    end
    idle(); idle();
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule